// File: doc/BRIEF.md
# Command Block Length Validator

This block screens the header of a combined request/response command block before any command is allowed to run. A caller presents the request length, the response length, a command code and the processor's problem-state flag together with a start strobe. One clock later the block raises a single-cycle done pulse with exactly one verdict. The verdict is a privilege fault, an operand fault, or accept. On accept the block also gives a response code and an execute flag that tells the external command model whether to run the payload.

Checks run in a fixed priority: privilege, request length, response length, combined length, exact request length, then command code. Only the first failing check decides the outcome. The length limits, the alignment, the combined buffer size, the exact request size, the response codes and the set of known command codes are all parameters. The values below are the defaults.

Top module: `cmd_block_validator`

## Requirements
- R1: When start is sampled with problem_state_i high, the verdict is a privilege fault, regardless of every other input.
- R2: Otherwise, a request length below 16, above 8184, or not a multiple of 8 gives an operand fault.
- R3: Otherwise, a response length below 8, above 8176, or not a multiple of 8 gives an operand fault.
- R4: Otherwise, a request length plus response length above 8192 gives an operand fault.
- R5: Otherwise, a request length other than 32 is accepted with response code 0x0008 and execute low.
- R6: Otherwise, a command code outside the known set {0x0001, 0x0002, 0x0003, 0x0004} is accepted with response code 0x0004 and execute low.
- R7: Otherwise, the request is accepted with response code 0x0010 and execute high.
- R8: The verdict appears in the cycle after start as a one-cycle done pulse with exactly one of privilege fault, operand fault or accept high. The response code is 0 and execute is low on any fault.
- R9: In a cycle that follows no start, done, all verdict flags, execute and the response code are 0, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, one cycle |
| problem_state_i | input | 1 | High when the caller runs unprivileged |
| req_len_i | input | 16 | Request length in bytes |
| rsp_len_i | input | 16 | Response length in bytes |
| cmd_i | input | 16 | Command code |
| done_o | output | 1 | One-cycle verdict pulse |
| priv_fault_o | output | 1 | Privilege fault verdict |
| oper_fault_o | output | 1 | Operand fault verdict |
| accept_o | output | 1 | Accept verdict |
| exec_o | output | 1 | Accepted and the command should execute |
| rsp_code_o | output | 16 | Response code on accept, else 0 |

## Verification
The bench targets each edge of the legal ranges (15/16, 8184/8185/8192, 7/8, 8176/8184) and lengths off the 8-byte grid by one. A design with an off-by-one comparison or a dropped alignment test would accept these lengths or fault on them wrongly. Pairs that sum to exactly 8192 and to 8200 check the combined cap. Fault-on-fault cases, such as problem state with bad lengths, or a bad response length paired with a non-32 request, show whether the priority order is kept. A wrong order would report an operand fault or an accept in place of the earlier fault. Idle cycles with noisy inputs catch a validator that reacts without a start.

// File: rtl/cbv_pkg.sv
package cbv_pkg;
   typedef enum logic [1:0] {
      VERD_NONE  = 2'd0,
      VERD_PRIV  = 2'd1,
      VERD_OPER  = 2'd2,
      VERD_ACCEPT = 2'd3
   } verdict_e;

   typedef struct packed {
      verdict_e    verdict;
      logic        run;
      logic [15:0] code;
   } outcome_t;
endpackage

// File: rtl/cbv_len_check.sv
module cbv_len_check #(
   parameter int W       = 16,
   parameter int MIN_LEN = 16,
   parameter int MAX_LEN = 8184,
   parameter int ALIGN   = 8
) (
   input  logic [W-1:0] len_i,
   output logic         ok_o
);
   localparam bit ALIGN_POW2 = (ALIGN & (ALIGN - 1)) == 0;
   localparam int ALIGN_BITS = (ALIGN > 1) ? $clog2(ALIGN) : 1;

   if (MIN_LEN > MAX_LEN) begin : g_bad_range
      $error("cbv_len_check: MIN_LEN above MAX_LEN");
   end
   if (ALIGN < 1) begin : g_bad_align
      $error("cbv_len_check: ALIGN must be positive");
   end
   if (MAX_LEN >= (1 << W)) begin : g_bad_width
      $error("cbv_len_check: MAX_LEN does not fit W");
   end

   logic in_range;
   logic aligned;

   assign in_range = (32'(len_i) >= 32'(MIN_LEN)) && (32'(len_i) <= 32'(MAX_LEN));

   if (ALIGN == 1) begin : g_no_align
      assign aligned = 1'b1;
   end else if (ALIGN_POW2) begin : g_mask_align
      assign aligned = (len_i[ALIGN_BITS-1:0] == '0);
   end else begin : g_mod_align
      assign aligned = ((32'(len_i) % 32'(ALIGN)) == 32'd0);
   end

   assign ok_o = in_range && aligned;
endmodule

// File: rtl/cbv_cmd_match.sv
module cbv_cmd_match #(
   parameter int CMD_W    = 16,
   parameter int NUM_CMDS = 4,
   parameter logic [NUM_CMDS-1:0][CMD_W-1:0] CMD_CODES = '{16'h0004, 16'h0003, 16'h0002, 16'h0001}
) (
   input  logic [CMD_W-1:0] cmd_i,
   output logic             hit_o
);
   if (NUM_CMDS < 1) begin : g_bad_count
      $error("cbv_cmd_match: NUM_CMDS must be at least 1");
   end

   logic [NUM_CMDS-1:0] hits;

   for (genvar i = 0; i < NUM_CMDS; i++) begin : g_cmp
      assign hits[i] = (cmd_i == CMD_CODES[i]);
   end

   assign hit_o = |hits;
endmodule

// File: rtl/cmd_block_validator.sv
module cmd_block_validator #(
   parameter int LEN_W     = 16,
   parameter int CMD_W     = 16,
   parameter int REQ_MIN   = 16,
   parameter int REQ_MAX   = 8184,
   parameter int RSP_MIN   = 8,
   parameter int RSP_MAX   = 8176,
   parameter int ALIGN     = 8,
   parameter int TOTAL_MAX = 8192,
   parameter int REQ_EXACT = 32,
   parameter int NUM_CMDS  = 4,
   parameter logic [NUM_CMDS-1:0][CMD_W-1:0] CMD_CODES = '{16'h0004, 16'h0003, 16'h0002, 16'h0001},
   parameter logic [15:0] CODE_OK     = 16'h0010,
   parameter logic [15:0] CODE_BADLEN = 16'h0008,
   parameter logic [15:0] CODE_BADCMD = 16'h0004
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             problem_state_i,
   input  logic [LEN_W-1:0] req_len_i,
   input  logic [LEN_W-1:0] rsp_len_i,
   input  logic [CMD_W-1:0] cmd_i,
   output logic             done_o,
   output logic             priv_fault_o,
   output logic             oper_fault_o,
   output logic             accept_o,
   output logic             exec_o,
   output logic [15:0]      rsp_code_o
);
   import cbv_pkg::*;

   localparam int SUM_W = LEN_W + 1;

   if (TOTAL_MAX >= (1 << SUM_W)) begin : g_bad_total
      $error("cmd_block_validator: TOTAL_MAX does not fit the sum width");
   end
   if (REQ_EXACT < REQ_MIN || REQ_EXACT > REQ_MAX) begin : g_bad_exact
      $error("cmd_block_validator: REQ_EXACT outside request range");
   end

   logic req_ok, rsp_ok, total_ok, cmd_hit;
   logic [SUM_W-1:0] total_len;

   cbv_len_check #(.W(LEN_W), .MIN_LEN(REQ_MIN), .MAX_LEN(REQ_MAX), .ALIGN(ALIGN))
      u_req_chk (.len_i(req_len_i), .ok_o(req_ok));

   cbv_len_check #(.W(LEN_W), .MIN_LEN(RSP_MIN), .MAX_LEN(RSP_MAX), .ALIGN(ALIGN))
      u_rsp_chk (.len_i(rsp_len_i), .ok_o(rsp_ok));

   cbv_cmd_match #(.CMD_W(CMD_W), .NUM_CMDS(NUM_CMDS), .CMD_CODES(CMD_CODES))
      u_cmd (.cmd_i(cmd_i), .hit_o(cmd_hit));

   assign total_len = SUM_W'(req_len_i) + SUM_W'(rsp_len_i);
   assign total_ok  = (32'(total_len) <= 32'(TOTAL_MAX));

   outcome_t next_out;

   always_comb begin
      next_out = '{verdict: VERD_NONE, run: 1'b0, code: 16'h0000};
      if (start_i) begin
         if (problem_state_i) begin
            next_out.verdict = VERD_PRIV;
         end else if (!req_ok || !rsp_ok || !total_ok) begin
            next_out.verdict = VERD_OPER;
         end else if (32'(req_len_i) != 32'(REQ_EXACT)) begin
            next_out.verdict = VERD_ACCEPT;
            next_out.code    = CODE_BADLEN;
         end else if (!cmd_hit) begin
            next_out.verdict = VERD_ACCEPT;
            next_out.code    = CODE_BADCMD;
         end else begin
            next_out.verdict = VERD_ACCEPT;
            next_out.code    = CODE_OK;
            next_out.run     = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_o       <= 1'b0;
         priv_fault_o <= 1'b0;
         oper_fault_o <= 1'b0;
         accept_o     <= 1'b0;
         exec_o       <= 1'b0;
         rsp_code_o   <= '0;
      end else begin
         done_o       <= start_i;
         priv_fault_o <= (next_out.verdict == VERD_PRIV);
         oper_fault_o <= (next_out.verdict == VERD_OPER);
         accept_o     <= (next_out.verdict == VERD_ACCEPT);
         exec_o       <= next_out.run;
         rsp_code_o   <= next_out.code;
      end
   end

   // R1
   priv_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && problem_state_i) |=> (priv_fault_o && !oper_fault_o && !accept_o));

   // R4
   total_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !problem_state_i && (32'(req_len_i) + 32'(rsp_len_i) > 32'(TOTAL_MAX)))
      |=> oper_fault_o);

   // R8
   one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $onehot({priv_fault_o, oper_fault_o, accept_o}));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> done_o);

   // R8
   fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_fault_o || oper_fault_o) |-> (rsp_code_o == 16'h0000 && !exec_o));

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> (!done_o && !priv_fault_o && !oper_fault_o && !accept_o && !exec_o
                    && rsp_code_o == 16'h0000));

   // R7
   exec_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exec_o |-> (accept_o && rsp_code_o == CODE_OK));
endmodule

// File: tb/cmd_block_validator_test.sv
module cmd_block_validator_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        problem_state_i = 1'b0;
   logic [15:0] req_len_i = '0;
   logic [15:0] rsp_len_i = '0;
   logic [15:0] cmd_i = '0;
   logic        done_o, priv_fault_o, oper_fault_o, accept_o, exec_o;
   logic [15:0] rsp_code_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmd_block_validator uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .problem_state_i(problem_state_i),
      .req_len_i(req_len_i), .rsp_len_i(rsp_len_i), .cmd_i(cmd_i),
      .done_o(done_o), .priv_fault_o(priv_fault_o), .oper_fault_o(oper_fault_o),
      .accept_o(accept_o), .exec_o(exec_o), .rsp_code_o(rsp_code_o));

   // packed expectation: {done, priv, oper, accept, exec, code[15:0]}
   function automatic logic [20:0] model(input bit ps, input int rq, input int rs, input int cmd);
      bit rq_ok, rs_ok;
      rq_ok = (rq >= 16) && (rq <= 8184) && (rq % 8 == 0);
      rs_ok = (rs >= 8) && (rs <= 8176) && (rs % 8 == 0);
      if (ps)                      return {5'b11000, 16'h0000};
      if (!rq_ok || !rs_ok)        return {5'b10100, 16'h0000};
      if (rq + rs > 8192)          return {5'b10100, 16'h0000};
      if (rq != 32)                return {5'b10010, 16'h0008};
      if (cmd < 1 || cmd > 4)      return {5'b10010, 16'h0004};
      return {5'b10011, 16'h0010};
   endfunction

   function automatic string tag(input bit ps, input int rq, input int rs, input int cmd);
      bit rq_ok, rs_ok;
      rq_ok = (rq >= 16) && (rq <= 8184) && (rq % 8 == 0);
      rs_ok = (rs >= 8) && (rs <= 8176) && (rs % 8 == 0);
      if (ps) return "R1";
      if (!rq_ok) return "R2";
      if (!rs_ok) return "R3";
      if (rq + rs > 8192) return "R4";
      if (rq != 32) return "R5";
      if (cmd < 1 || cmd > 4) return "R6";
      return "R7";
   endfunction

   function automatic logic [20:0] seen();
      return {done_o, priv_fault_o, oper_fault_o, accept_o, exec_o, rsp_code_o};
   endfunction

   task automatic compare(input string req, input logic [20:0] act, input logic [20:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drives one request on a falling edge, samples one falling edge later,
   // then checks the following cycle is quiet while inputs carry noise
   task automatic run(input bit ps, input int rq, input int rs, input int cmd);
      @(negedge clk);
      start_i = 1'b1; problem_state_i = ps;
      req_len_i = 16'(rq); rsp_len_i = 16'(rs); cmd_i = 16'(cmd);
      @(negedge clk);
      start_i = 1'b0;
      req_len_i = 16'($urandom); rsp_len_i = 16'($urandom); cmd_i = 16'($urandom);
      problem_state_i = 1'($urandom);
      compare({tag(ps, rq, rs, cmd), "/R8"}, seen(), model(ps, rq, rs, cmd));
      @(negedge clk);
      compare("R9", seen(), 21'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_c0de));
      repeat (3) @(negedge clk);
      compare("R9 reset", seen(), 21'h0);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R9 after reset", seen(), 21'h0);

      // R1 privilege beats everything
      run(1, 32, 64, 1);
      run(1, 3, 9000, 99);
      // R2 request bounds and alignment
      run(0, 8, 64, 1);
      run(0, 15, 64, 1);
      run(0, 16, 64, 1);
      run(0, 8184, 8, 1);
      run(0, 8185, 8, 1);
      run(0, 8192, 8, 1);
      run(0, 33, 64, 2);
      // R3 response bounds and alignment
      run(0, 32, 0, 1);
      run(0, 32, 7, 1);
      run(0, 32, 8, 1);
      run(0, 32, 8176, 1);
      run(0, 32, 8184, 1);
      run(0, 32, 65, 3);
      run(0, 40, 9, 1);
      // R4 total cap
      run(0, 16, 8176, 1);
      run(0, 24, 8176, 1);
      run(0, 8184, 8, 4);
      run(0, 8184, 16, 4);
      // R5 exact length
      run(0, 24, 64, 1);
      run(0, 40, 64, 9);
      // R6 unknown command
      run(0, 32, 64, 0);
      run(0, 32, 64, 5);
      run(0, 32, 64, 16'hffff);
      // R7 known commands
      for (int c = 1; c <= 4; c++) run(0, 32, 128, c);

      // back-to-back starts: R8 done each cycle
      @(negedge clk);
      start_i = 1'b1; problem_state_i = 0; req_len_i = 32; rsp_len_i = 64; cmd_i = 2;
      @(negedge clk);
      cmd_i = 7;
      compare("R8 b2b first", seen(), model(0, 32, 64, 2));
      @(negedge clk);
      start_i = 1'b0;
      compare("R8 b2b second", seen(), model(0, 32, 64, 7));
      @(negedge clk);
      compare("R9 b2b idle", seen(), 21'h0);

      // random mix
      for (int i = 0; i < 600; i++) begin
         int rq, rs, cmd, sel;
         bit ps;
         sel = int'($urandom_range(0, 3));
         rq  = (sel == 0) ? 32 : (sel == 1) ? int'($urandom_range(0, 1100)) * 8
                                            : int'($urandom_range(0, 8300));
         sel = int'($urandom_range(0, 2));
         rs  = (sel == 0) ? int'($urandom_range(1, 40)) * 8
             : (sel == 1) ? int'($urandom_range(1000, 1040)) * 8
                          : int'($urandom_range(0, 8300));
         cmd = int'($urandom_range(0, 6));
         ps  = ($urandom_range(0, 9) == 0);
         run(ps, rq, rs, cmd);
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule